// File: doc/BRIEF.md
# Lazy Register Context Swap Unit

This block owns a 64-entry, 64-bit register file together with an on-chip backing store that holds a saved copy of every register for each of four thread contexts. When a thread switch is accepted, the register file is not saved and reloaded in bulk. Instead, every register gets a hidden pending flag, and all 64 flags are armed in the same cycle. After that, the first time the incoming context touches a register, that register's live value is written to the outgoing context's slot. For a read, the incoming context's saved value is then loaded in its place. Registers that are never touched keep their flag and cost no bandwidth until later.

The pipeline reaches the block through one read port and one write port. It holds its request steady while `stall` is high. A switch request carries the outgoing and incoming context numbers and is held until `sw_ack`. If flags are still armed when a new switch arrives, the block first completes every remaining swap, lowest register index first, and only then accepts the switch.

The controller has three states:
- `ST_RUN`: normal operation.
- `ST_FILL`: the one cycle in which a demand-read swap loads the incoming value.
- `ST_SWEEP`: completing all leftover swaps before a switch.

The transitions are:
- RUN→FILL on a read of a pending register.
- RUN→RUN on a write-only swap, on an accepted switch, or on a clean access.
- FILL→RUN always.
- RUN→SWEEP on a switch request while any flag is set.
- SWEEP→SWEEP while flags remain.
- SWEEP→RUN on the cycle that loads the last swept register.

Top module: `lazy_ctx_swap`

## Requirements
- R1: After reset the register file reads zero in context 0, no flag is armed, `stall` and `sw_ack` are low, and accesses proceed without stall.
- R2: A switch request made while no flag is armed is acknowledged in the same cycle (`sw_ack` high while `sw_req` is high), and all 64 pending flags are set from the next cycle.
- R3: A read of a pending register holds `stall` high for exactly 2 cycles (save out, then load in). The read then returns the incoming context's saved value.
- R4: A write to a pending register (with no pending read) holds `stall` high for exactly 1 cycle. The old value goes to the outgoing context's slot, no load takes place, and the written value is what later reads of that register return.
- R5: An access whose registers are not pending completes with no stall.
- R6: A register's flag clears when its swap is issued, so a second access to it completes without stall.
- R7: Every context keeps its own register values across any number of switches, including registers that were never touched while another context ran.
- R8: A switch request made while k > 0 flags are armed is acknowledged after exactly k+2 stalled cycles. During the sweep, each cycle clears the lowest-numbered armed flag.
- R9: When one access reads pending register a and writes pending register b with a ≠ b, the read swap is served first: 3 stall cycles in total. If a = b, only the 2-cycle read swap occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request from pipeline |
| rd_idx | input | 6 | Register number to read |
| rd_data | output | 64 | Read value, valid when `rd_en` and not `stall` |
| wr_en | input | 1 | Write request from pipeline |
| wr_idx | input | 6 | Register number to write |
| wr_data | input | 64 | Value to write |
| stall | output | 1 | Pipeline must hold its request this cycle |
| sw_req | input | 1 | Context switch request, held until acknowledged |
| sw_from | input | 2 | Outgoing context number |
| sw_to | input | 2 | Incoming context number (must differ from `sw_from`) |
| sw_ack | output | 1 | Switch accepted this cycle |

## Verification
The bench counts the exact number of stall cycles for reads and writes that hit pending registers, alone and combined in one access. A design that loaded on a write, or that swapped the write before the read, shows a wrong count or returns a stale value. It follows registers through chains of switches in which some are left untouched, then returns to earlier contexts. A sweep that saved to the wrong slot, or that skipped an armed register, then hands back the wrong value. It also times the acknowledge of a switch against the number of armed flags, which catches a sweep that drops or repeats entries.

// File: rtl/lzs_pkg.sv
package lzs_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FILL  = 2'd1,
        ST_SWEEP = 2'd2
    } lzs_state_e;

endpackage

// File: rtl/lzs_flag_bank.sv
module lzs_flag_bank #(
    parameter int NREG = 64,
    localparam int IW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_all,
    input  logic            clr_en,
    input  logic [IW-1:0]   clr_idx,
    output logic [NREG-1:0] flags,
    output logic            any,
    output logic [IW-1:0]   low_idx
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (set_all) begin
            flags <= '1;
        end else if (clr_en) begin
            flags[clr_idx] <= 1'b0;
        end
    end

    // lowest armed index, scanned high to low so the smallest wins
    always_comb begin
        any     = |flags;
        low_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (flags[i]) begin
                low_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/lzs_regfile.sv
module lzs_regfile #(
    parameter int NREG = 64,
    parameter int W = 64,
    localparam int IW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_a,
    input  logic [IW-1:0] idx_a,
    input  logic [W-1:0]  d_a,
    input  logic          we_b,
    input  logic [IW-1:0] idx_b,
    input  logic [W-1:0]  d_b,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else begin
            if (we_a) begin
                regs[idx_a] <= d_a;
            end
            if (we_b) begin
                regs[idx_b] <= d_b;
            end
        end
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];

endmodule

// File: rtl/lzs_backing_ram.sv
module lzs_backing_ram #(
    parameter int DEPTH = 256,
    parameter int W = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/lzs_ctrl.sv
module lzs_ctrl
    import lzs_pkg::*;
#(
    parameter int NREG = 64,
    parameter int NCTX = 4,
    localparam int IW = $clog2(NREG),
    localparam int CW = $clog2(NCTX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_req,
    input  logic [CW-1:0] sw_from,
    input  logic [CW-1:0] sw_to,
    input  logic [IW-1:0] rd_idx,
    input  logic [IW-1:0] wr_idx,
    input  logic          rd_hit,
    input  logic          wr_hit,
    input  logic          any_pend,
    input  logic [IW-1:0] low_idx,
    output logic          stall,
    output logic          sw_ack,
    output logic          set_all,
    output logic          clr_en,
    output logic [IW-1:0] swap_idx,
    output logic          ram_we,
    output logic          ram_re,
    output logic          load_en,
    output logic [IW-1:0] load_idx,
    output logic [CW-1:0] ctx_out,
    output logic [CW-1:0] ctx_in,
    output lzs_state_e    st
);

    lzs_state_e nxt;
    logic       issue;
    logic       want_load;
    logic       load_v;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_RUN;
        end else begin
            st <= nxt;
        end
    end

    // load tracking and latched context pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_v   <= 1'b0;
            load_idx <= '0;
            ctx_out  <= '0;
            ctx_in   <= '0;
        end else begin
            load_v   <= issue && want_load;
            load_idx <= swap_idx;
            if (sw_ack) begin
                ctx_out <= sw_from;
                ctx_in  <= sw_to;
            end
        end
    end

    // next state and outputs
    always_comb begin
        nxt       = st;
        stall     = 1'b0;
        sw_ack    = 1'b0;
        set_all   = 1'b0;
        issue     = 1'b0;
        want_load = 1'b0;
        swap_idx  = low_idx;
        load_en   = 1'b0;
        unique case (st)
            ST_RUN: begin
                if (sw_req) begin
                    if (any_pend) begin
                        stall = 1'b1;
                        nxt   = ST_SWEEP;
                    end else begin
                        sw_ack  = 1'b1;
                        set_all = 1'b1;
                    end
                end else if (rd_hit) begin
                    stall     = 1'b1;
                    issue     = 1'b1;
                    want_load = 1'b1;
                    swap_idx  = rd_idx;
                    nxt       = ST_FILL;
                end else if (wr_hit) begin
                    stall    = 1'b1;
                    issue    = 1'b1;
                    swap_idx = wr_idx;
                end
            end
            ST_FILL: begin
                stall   = 1'b1;
                load_en = load_v;
                nxt     = ST_RUN;
            end
            ST_SWEEP: begin
                stall   = 1'b1;
                load_en = load_v;
                if (any_pend) begin
                    issue     = 1'b1;
                    want_load = 1'b1;
                    swap_idx  = low_idx;
                end else begin
                    nxt = ST_RUN;
                end
            end
            default: begin
                nxt = ST_RUN;
            end
        endcase
        clr_en = issue;
        ram_we = issue;
        ram_re = issue && want_load;
    end

endmodule

// File: rtl/lazy_ctx_swap.sv
module lazy_ctx_swap
    import lzs_pkg::*;
#(
    parameter int NREG = 64,
    parameter int NCTX = 4,
    parameter int W = 64,
    localparam int IW = $clog2(NREG),
    localparam int CW = $clog2(NCTX),
    localparam int DEPTH = NREG * NCTX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    output logic          stall,
    input  logic          sw_req,
    input  logic [CW-1:0] sw_from,
    input  logic [CW-1:0] sw_to,
    output logic          sw_ack
);

    logic [NREG-1:0] pend;
    logic            any_pend;
    logic [IW-1:0]   low_idx;
    logic            set_all;
    logic            clr_en;
    logic [IW-1:0]   swap_idx;
    logic            ram_we;
    logic            ram_re;
    logic            load_en;
    logic [IW-1:0]   load_idx;
    logic [CW-1:0]   ctx_out;
    logic [CW-1:0]   ctx_in;
    logic [W-1:0]    save_data;
    logic [W-1:0]    ram_rdata;
    lzs_state_e      st;
    logic            rd_hit;
    logic            wr_hit;

    assign rd_hit = rd_en && pend[rd_idx];
    assign wr_hit = wr_en && pend[wr_idx];

    lzs_flag_bank #(.NREG(NREG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_all (set_all),
        .clr_en  (clr_en),
        .clr_idx (swap_idx),
        .flags   (pend),
        .any     (any_pend),
        .low_idx (low_idx)
    );

    lzs_ctrl #(.NREG(NREG), .NCTX(NCTX)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_req   (sw_req),
        .sw_from  (sw_from),
        .sw_to    (sw_to),
        .rd_idx   (rd_idx),
        .wr_idx   (wr_idx),
        .rd_hit   (rd_hit),
        .wr_hit   (wr_hit),
        .any_pend (any_pend),
        .low_idx  (low_idx),
        .stall    (stall),
        .sw_ack   (sw_ack),
        .set_all  (set_all),
        .clr_en   (clr_en),
        .swap_idx (swap_idx),
        .ram_we   (ram_we),
        .ram_re   (ram_re),
        .load_en  (load_en),
        .load_idx (load_idx),
        .ctx_out  (ctx_out),
        .ctx_in   (ctx_in),
        .st       (st)
    );

    lzs_regfile #(.NREG(NREG), .W(W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_a    (wr_en && !stall),
        .idx_a   (wr_idx),
        .d_a     (wr_data),
        .we_b    (load_en),
        .idx_b   (load_idx),
        .d_b     (ram_rdata),
        .ra_idx  (rd_idx),
        .ra_data (rd_data),
        .rb_idx  (swap_idx),
        .rb_data (save_data)
    );

    lzs_backing_ram #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk   (clk),
        .we    (ram_we),
        .waddr ({ctx_out, swap_idx}),
        .wdata (save_data),
        .re    (ram_re),
        .raddr ({ctx_in, swap_idx}),
        .rdata (ram_rdata)
    );

endmodule

// File: rtl/lzs_checker.sv
module lzs_checker
    import lzs_pkg::*;
#(
    parameter int NREG = 64,
    localparam int IW = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input lzs_state_e      st,
    input logic [NREG-1:0] pend,
    input logic            stall,
    input logic            sw_req,
    input logic            sw_ack,
    input logic            rd_en,
    input logic [IW-1:0]   rd_idx,
    input logic            wr_en,
    input logic [IW-1:0]   wr_idx
);

    // R2
    ack_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ack |-> (pend == '0));

    // R2
    ack_arms_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ack |=> (&pend));

    // R3
    fill_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL) |=> (st == ST_RUN));

    // R5
    clean_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !sw_req && !(rd_en && pend[rd_idx]) && !(wr_en && pend[wr_idx])) |-> !stall);

    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !sw_req && rd_en && pend[rd_idx]) |=> !pend[$past(rd_idx)]);

    // R8
    sweep_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SWEEP && pend != '0) |=> (pend == $past(pend & (pend - NREG'(1)))));

    // R8
    sweep_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SWEEP) |-> (stall && !sw_ack));

endmodule

bind lazy_ctx_swap lzs_checker #(.NREG(NREG)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .st     (st),
    .pend   (pend),
    .stall  (stall),
    .sw_req (sw_req),
    .sw_ack (sw_ack),
    .rd_en  (rd_en),
    .rd_idx (rd_idx),
    .wr_en  (wr_en),
    .wr_idx (wr_idx)
);

// File: tb/tb_lazy_ctx_swap.sv
`timescale 1ns/1ps
module tb_lazy_ctx_swap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        stall;
    logic        sw_req = 1'b0;
    logic [1:0]  sw_from = '0;
    logic [1:0]  sw_to = '0;
    logic        sw_ack;

    int errors = 0;
    int checks = 0;

    logic [63:0] arch [4][64];
    bit          known [4][64];
    logic [63:0] pend_m;
    int          cur;

    always #2.5 clk = ~clk;

    lazy_ctx_swap dut (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .stall(stall),
        .sw_req(sw_req), .sw_from(sw_from), .sw_to(sw_to), .sw_ack(sw_ack)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_stalls(input bit re, input int ri, input bit we, input int wi);
        bit pr = re && pend_m[ri];
        bit pw = we && pend_m[wi] && !(pr && wi == ri);
        return (pr ? 2 : 0) + (pw ? 1 : 0);
    endfunction

    task automatic do_access(input bit re, input int ri, input bit we, input int wi,
                             input logic [63:0] wd, input string tag);
        int cnt = 0;
        int exp = exp_stalls(re, ri, we, wi);
        @(negedge clk);
        rd_en = re; rd_idx = 6'(ri);
        wr_en = we; wr_idx = 6'(wi); wr_data = wd;
        #1;
        while (stall && cnt < 50) begin
            cnt++;
            @(negedge clk);
            #1;
        end
        chk(cnt == exp, tag, 64'(cnt), 64'(exp));
        if (re && known[cur][ri])
            chk(rd_data == arch[cur][ri], tag, rd_data, arch[cur][ri]);
        @(posedge clk);
        #1;
        rd_en = 1'b0; wr_en = 1'b0;
        if (re) pend_m[ri] = 1'b0;
        if (we) begin
            pend_m[wi] = 1'b0;
            arch[cur][wi] = wd;
            known[cur][wi] = 1'b1;
        end
    endtask

    task automatic do_switch(input int to, input string tag);
        int cnt = 0;
        int k = $countones(pend_m);
        int exp = (k == 0) ? 0 : k + 2;
        @(negedge clk);
        sw_req = 1'b1; sw_from = 2'(cur); sw_to = 2'(to);
        #1;
        while (!sw_ack && cnt < 200) begin
            cnt++;
            @(negedge clk);
            #1;
        end
        chk(cnt == exp, tag, 64'(cnt), 64'(exp));
        @(posedge clk);
        #1;
        sw_req = 1'b0;
        pend_m = '1;
        cur = to;
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 64; r++) begin
                arch[c][r] = '0;
                known[c][r] = (c == 0);
            end
        pend_m = '0;
        cur = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(stall == 1'b0, "R1", 64'(stall), 64'(0));
        chk(sw_ack == 1'b0, "R1", 64'(sw_ack), 64'(0));
        do_access(1, 5, 0, 0, 0, "R1");
        do_access(1, 63, 0, 0, 0, "R1");

        // seed every context through full writes (R4 write-only swaps, R2 instant accept)
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 64; r++)
                do_access(0, 0, 1, r, rnd64(), (c == 0) ? "R5" : "R4");
            do_switch((c + 1) % 4, "R2");
        end

        // directed corner cases in context 0, all armed
        do_access(1, 3, 0, 0, 0, "R3");
        do_access(1, 3, 0, 0, 0, "R6");
        do_access(1, 10, 1, 11, rnd64(), "R9");
        do_access(1, 20, 1, 20, rnd64(), "R9");
        do_access(0, 0, 1, 30, 64'hdead_beef_0000_0030, "R4");
        do_access(1, 30, 0, 0, 0, "R6");
        do_switch(1, "R8");
        do_access(1, 7, 0, 0, 0, "R3");
        do_switch(2, "R8");
        do_switch(0, "R8");
        do_access(1, 30, 0, 0, 0, "R7");
        do_access(1, 40, 0, 0, 0, "R7");
        do_access(1, 0, 0, 0, 0, "R7");

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int sel = $urandom_range(0, 99);
            int ra = $urandom_range(0, 7) + (($urandom_range(0, 3) == 0) ? 56 : 0);
            int wa = $urandom_range(0, 7) + (($urandom_range(0, 3) == 0) ? 56 : 0);
            if (sel < 4) begin
                int to = (cur + $urandom_range(1, 3)) % 4;
                do_switch(to, "R8");
            end else if (sel < 50) begin
                do_access(1, ra, 0, 0, 0, "R7");
            end else if (sel < 85) begin
                do_access(0, 0, 1, wa, rnd64(), "R4");
            end else begin
                do_access(1, ra, 1, wa, rnd64(), "R9");
            end
        end

        // final sweep through all contexts checks retained values
        for (int c = 1; c <= 4; c++) begin
            do_switch((cur + 1) % 4, "R8");
            for (int r = 0; r < 64; r += 9)
                do_access(1, r, 0, 0, 0, "R7");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule